// File: doc/BRIEF.md
# Reset Release Sequencer with Retries

This block brings a graphics device and a host processor out of reset in a fixed order and checks that each step actually took effect. A start pulse first holds both reset lines low for a set number of millisecond ticks. It then releases the graphics reset and waits for the device's reset-done signal. Next it waits for the PCIe link status to report L0. Finally it releases the processor reset and waits for the host's power-up-cause query, which arrives as a one-cycle handshake strobe. Each of the three waits has its own timeout, counted in ticks.

When a wait times out, the block pulses an error log strobe carrying a code for the stage that failed, and increments an attempt counter. If the counter is still below its limit, both resets are driven low again and the whole release runs again from the start. The counter is not cleared on this retry. When the counter reaches the limit, the block stops in a terminal error that names the failing stage. After a good handshake it reports running and keeps both resets released. A new start pulse is the only way out of the running state or the terminal error.

Top module: `rst_release_seq`

## Requirements
- R1: After reset, both reset outputs are low, running is 0, the log strobe is 0 and the terminal code is 0 (none).
- R2: A start pulse while idle, running or in terminal error clears the attempt count and the terminal code. It then drives both resets low for HOLD_TICKS ticks, after which the graphics reset goes high while the processor reset stays low.
- R3: While waiting for reset-done, a high reset-done input moves on to the link wait. If GPU_TMO ticks pass without it, the stage times out.
- R4: While waiting for the link, a high L0 input moves on to the handshake wait. If LINK_TMO ticks pass without it, the stage times out.
- R5: Once L0 is seen, the processor reset goes high one cycle later, and the processor reset is never high while the graphics reset is low. If HS_TMO ticks then pass without a handshake strobe, the stage times out.
- R6: Each timeout gives a log strobe one cycle wide, with code 1 for reset-done, 2 for link and 3 for handshake. The log code reads 0 when the strobe is low.
- R7: Each timeout increments the attempt count, whatever stage it comes from. When the count reaches MAX_TRIES, the block enters terminal error with the same stage code (1, 2 or 3), holds both resets low, and keeps that code until the next start.
- R8: A timeout that leaves the count below MAX_TRIES drives both resets low for HOLD_TICKS ticks and then restarts the release. The count is kept.
- R9: A handshake strobe during the handshake wait sets running to 1 with both resets high, and this lasts until the next start.
- R10: A start pulse during the hold or any wait stage is ignored.
- R11: If a confirmation arrives in the same cycle as the tick that would expire its stage, the confirmation wins and nothing is logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| tick_i | input | 1 | Millisecond tick, one cycle wide |
| gpu_done_i | input | 1 | Graphics reset-done status |
| link_l0_i | input | 1 | PCIe link in L0 |
| hs_strobe_i | input | 1 | Host power-up-cause query strobe |
| gpu_rst_n_o | output | 1 | Graphics reset, active low |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| running_o | output | 1 | Sequence completed |
| log_vld_o | output | 1 | Error log strobe |
| log_code_o | output | 2 | Logged stage code (1 reset-done, 2 link, 3 handshake) |
| fatal_code_o | output | 2 | Terminal error code, 0 when none |

## Verification
Every output comes from a register. A start pulse, a confirmation or an expiring tick that is present at one rising edge therefore shows on the ports right after that edge. The log strobe and the terminal code appear at the same edge on which the state leaves the wait. The bench drives its inputs at the falling edge. A behavioural model advances at the rising edge, and the model and the outputs are compared at the next falling edge, so each result is checked in the very cycle it is due. The corner cases are set up from the model's own tick count. These are the case where a confirmation coincides with the final tick, and the carry-over of the attempt count through retries across different stages.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_WGPU  = 3'd2,
    ST_WLINK = 3'd3,
    ST_WHS   = 3'd4,
    ST_RUN   = 3'd5,
    ST_FATAL = 3'd6
  } rrs_state_e;

  typedef enum logic [1:0] {
    CODE_NONE = 2'd0,
    CODE_GPU  = 2'd1,
    CODE_LINK = 2'd2,
    CODE_HS   = 2'd3
  } rrs_code_e;

  function automatic int unsigned rrs_max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rrs_tick_timer.sv
module rrs_tick_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [TW-1:0] cnt_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i || (tick_i && (cnt_q != {TW{1'b1}}));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3
  tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/rrs_attempt_ctr.sv
module rrs_attempt_ctr #(
  parameter int unsigned MAX_TRIES = 3,
  parameter int unsigned AW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] cnt_o,
  output logic          last_o
);

  localparam logic [AW-1:0] CAP  = AW'(MAX_TRIES);
  localparam logic [AW-1:0] LAST = AW'(MAX_TRIES - 1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i || (inc_i && (cnt_q != CAP));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q >= LAST);

  // R8
  keep_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(cnt_o));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CAP);

endmodule

// File: rtl/rrs_seq_fsm.sv
module rrs_seq_fsm
  import rrs_pkg::*;
#(
  parameter int unsigned TW         = 8,
  parameter int unsigned HOLD_TICKS = 10,
  parameter int unsigned GPU_TMO    = 50,
  parameter int unsigned LINK_TMO   = 100,
  parameter int unsigned HS_TMO     = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          gpu_done_i,
  input  logic          link_l0_i,
  input  logic          hs_strobe_i,
  input  logic [TW-1:0] tmr_cnt_i,
  input  logic          att_last_i,
  output logic          tmr_clr_o,
  output logic          att_clr_o,
  output logic          att_inc_o,
  output logic          gpu_rst_n_o,
  output logic          cpu_rst_n_o,
  output logic          running_o,
  output logic          log_vld_o,
  output logic [1:0]    log_code_o,
  output logic [1:0]    fatal_code_o
);

  localparam logic [TW-1:0] HOLD_L = TW'(HOLD_TICKS - 1);
  localparam logic [TW-1:0] GPU_L  = TW'(GPU_TMO - 1);
  localparam logic [TW-1:0] LINK_L = TW'(LINK_TMO - 1);
  localparam logic [TW-1:0] HS_L   = TW'(HS_TMO - 1);

  rrs_state_e    state_q, state_d;
  rrs_code_e     fatal_q, fatal_d;
  rrs_code_e     code_q, code_d;
  rrs_code_e     stage_code;
  logic          log_q, log_d;
  logic [TW-1:0] lim;
  logic          expire;
  logic          tmo;

  // per-state tick limit and stage code
  always_comb begin
    lim        = HOLD_L;
    stage_code = CODE_NONE;
    unique case (state_q)
      ST_WGPU:  begin lim = GPU_L;  stage_code = CODE_GPU;  end
      ST_WLINK: begin lim = LINK_L; stage_code = CODE_LINK; end
      ST_WHS:   begin lim = HS_L;   stage_code = CODE_HS;   end
      default:  begin lim = HOLD_L; stage_code = CODE_NONE; end
    endcase
  end

  assign expire = tick_i && (tmr_cnt_i == lim);

  // next-state logic
  always_comb begin
    state_d   = state_q;
    fatal_d   = fatal_q;
    att_clr_o = 1'b0;
    tmo       = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_RUN, ST_FATAL: begin
        if (start_i) begin
          state_d   = ST_HOLD;
          att_clr_o = 1'b1;
          fatal_d   = CODE_NONE;
        end
      end
      ST_HOLD: begin
        if (expire) state_d = ST_WGPU;
      end
      ST_WGPU: begin
        if (gpu_done_i)  state_d = ST_WLINK;
        else if (expire) tmo     = 1'b1;
      end
      ST_WLINK: begin
        if (link_l0_i)   state_d = ST_WHS;
        else if (expire) tmo     = 1'b1;
      end
      ST_WHS: begin
        if (hs_strobe_i) state_d = ST_RUN;
        else if (expire) tmo     = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (tmo) begin
      if (att_last_i) begin
        state_d = ST_FATAL;
        fatal_d = stage_code;
      end else begin
        state_d = ST_HOLD;
      end
    end
  end

  assign att_inc_o = tmo;
  assign log_d     = tmo;
  assign code_d    = tmo ? stage_code : CODE_NONE;
  assign tmr_clr_o = (state_d != state_q);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fatal_q <= CODE_NONE;
      code_q  <= CODE_NONE;
      log_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fatal_q <= fatal_d;
      code_q  <= code_d;
      log_q   <= log_d;
    end
  end

  // output decode
  assign gpu_rst_n_o  = (state_q == ST_WGPU) || (state_q == ST_WLINK) ||
                        (state_q == ST_WHS)  || (state_q == ST_RUN);
  assign cpu_rst_n_o  = (state_q == ST_WHS)  || (state_q == ST_RUN);
  assign running_o    = (state_q == ST_RUN);
  assign log_vld_o    = log_q;
  assign log_code_o   = code_q;
  assign fatal_code_o = fatal_q;

  // R6
  log_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_vld_o |-> (log_code_o != 2'd0));

  // R6
  log_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_vld_o |=> !log_vld_o);

  // R7
  fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fatal_code_o != 2'd0) && !start_i) |=> $stable(fatal_code_o));

  // R7
  fatal_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_code_o != 2'd0) |-> (!gpu_rst_n_o && !cpu_rst_n_o));

  // R5
  rst_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n_o |-> gpu_rst_n_o);

  // R9
  run_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !start_i) |=> (running_o && gpu_rst_n_o && cpu_rst_n_o));

endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rrs_pkg::*;
#(
  parameter int unsigned MAX_TRIES  = 3,
  parameter int unsigned HOLD_TICKS = 10,
  parameter int unsigned GPU_TMO    = 50,
  parameter int unsigned LINK_TMO   = 100,
  parameter int unsigned HS_TMO     = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tick_i,
  input  logic       gpu_done_i,
  input  logic       link_l0_i,
  input  logic       hs_strobe_i,
  output logic       gpu_rst_n_o,
  output logic       cpu_rst_n_o,
  output logic       running_o,
  output logic       log_vld_o,
  output logic [1:0] log_code_o,
  output logic [1:0] fatal_code_o
);

  localparam int unsigned T_MAX = rrs_max2(rrs_max2(HOLD_TICKS, GPU_TMO),
                                           rrs_max2(LINK_TMO, HS_TMO));
  localparam int unsigned TW    = $clog2(T_MAX + 1);
  localparam int unsigned AW    = $clog2(MAX_TRIES + 1);

  logic [TW-1:0] tmr_cnt;
  logic          tmr_clr;
  logic [AW-1:0] att_cnt;
  logic          att_last;
  logic          att_clr;
  logic          att_inc;

  rrs_tick_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmr_clr),
    .tick_i (tick_i),
    .cnt_o  (tmr_cnt)
  );

  rrs_attempt_ctr #(.MAX_TRIES(MAX_TRIES), .AW(AW)) u_attempts (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (att_clr),
    .inc_i  (att_inc),
    .cnt_o  (att_cnt),
    .last_o (att_last)
  );

  rrs_seq_fsm #(
    .TW         (TW),
    .HOLD_TICKS (HOLD_TICKS),
    .GPU_TMO    (GPU_TMO),
    .LINK_TMO   (LINK_TMO),
    .HS_TMO     (HS_TMO)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .tick_i       (tick_i),
    .gpu_done_i   (gpu_done_i),
    .link_l0_i    (link_l0_i),
    .hs_strobe_i  (hs_strobe_i),
    .tmr_cnt_i    (tmr_cnt),
    .att_last_i   (att_last),
    .tmr_clr_o    (tmr_clr),
    .att_clr_o    (att_clr),
    .att_inc_o    (att_inc),
    .gpu_rst_n_o  (gpu_rst_n_o),
    .cpu_rst_n_o  (cpu_rst_n_o),
    .running_o    (running_o),
    .log_vld_o    (log_vld_o),
    .log_code_o   (log_code_o),
    .fatal_code_o (fatal_code_o)
  );

  // R7
  att_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_code_o != 2'd0) |-> (att_cnt == AW'(MAX_TRIES)));

endmodule

// File: tb/rst_release_seq_tb.sv
module rst_release_seq_tb;

  localparam int MAXT = 3;
  localparam int HOLD = 3;
  localparam int GT   = 5;
  localparam int LT   = 6;
  localparam int HT   = 7;
  localparam int WD   = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start_i, tick_i, gpu_done_i, link_l0_i, hs_strobe_i;
  logic gpu_rst_n_o, cpu_rst_n_o, running_o, log_vld_o;
  logic [1:0] log_code_o, fatal_code_o;

  rst_release_seq #(
    .MAX_TRIES(MAXT), .HOLD_TICKS(HOLD), .GPU_TMO(GT), .LINK_TMO(LT), .HS_TMO(HT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .gpu_done_i(gpu_done_i), .link_l0_i(link_l0_i), .hs_strobe_i(hs_strobe_i),
    .gpu_rst_n_o(gpu_rst_n_o), .cpu_rst_n_o(cpu_rst_n_o), .running_o(running_o),
    .log_vld_o(log_vld_o), .log_code_o(log_code_o), .fatal_code_o(fatal_code_o)
  );

  // reference model: 0 idle,1 hold,2 wait gpu,3 wait link,4 wait hs,5 run,6 fatal
  int m_st, m_tc, m_att, m_lv, m_lc, m_fc;
  int nchk = 0, nerr = 0, cyc = 0;
  bit auto_tick = 1, force_tick = 0, start_req = 0, hs_req = 0;

  task automatic m_timeout(input int code);
    m_att++;
    m_lv = 1;
    m_lc = code;
    m_tc = 0;
    if (m_att >= MAXT) begin m_st = 6; m_fc = code; end
    else m_st = 1;
  endtask

  task automatic m_wait(input bit ok, input int nxt, input int lim, input int code);
    if (ok) begin m_st = nxt; m_tc = 0; end
    else if (tick_i) begin
      if (m_tc == lim - 1) m_timeout(code);
      else m_tc++;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_tc = 0; m_att = 0; m_lv = 0; m_lc = 0; m_fc = 0;
    end else begin
      m_lv = 0; m_lc = 0;
      case (m_st)
        0, 5, 6: if (start_i) begin m_st = 1; m_tc = 0; m_att = 0; m_fc = 0; end
        1: if (tick_i) begin
             if (m_tc == HOLD - 1) begin m_st = 2; m_tc = 0; end
             else m_tc++;
           end
        2: m_wait(gpu_done_i, 3, GT, 1);
        3: m_wait(link_l0_i, 4, LT, 2);
        4: m_wait(hs_strobe_i, 5, HT, 3);
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  task automatic compare();
    string t;
    case (m_st)
      0: t = "R1"; 1: t = "R2"; 2: t = "R3"; 3: t = "R4";
      4: t = "R5"; 5: t = "R9"; default: t = "R7";
    endcase
    chk(t, "gpu_rst_n", gpu_rst_n_o, (m_st >= 2 && m_st <= 5));
    chk(t, "cpu_rst_n", cpu_rst_n_o, (m_st == 4 || m_st == 5));
    chk(t, "running", running_o, (m_st == 5));
    chk("R6", "log_vld", log_vld_o, m_lv);
    chk("R6", "log_code", log_code_o, m_lc);
    chk("R7", "fatal_code", fatal_code_o, m_fc);
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (rst_n) compare();
    tick_i      = force_tick | (auto_tick && (cyc % 3 == 0));
    force_tick  = 0;
    start_i     = start_req;
    start_req   = 0;
    hs_strobe_i = hs_req;
    hs_req      = 0;
    if (cyc > WD) begin
      nerr++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  endtask

  task automatic wait_st(input int s);
    for (int i = 0; i < 3000; i++) begin
      if (m_st == s) return;
      step();
    end
    chk("R2", "reach model state", m_st, s);
  endtask

  initial begin
    rst_n = 0; start_i = 0; tick_i = 0; gpu_done_i = 0; link_l0_i = 0; hs_strobe_i = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1", "gpu_rst_n", gpu_rst_n_o, 0);
    chk("R1", "cpu_rst_n", cpu_rst_n_o, 0);
    chk("R1", "running", running_o, 0);
    chk("R1", "fatal_code", fatal_code_o, 0);

    // R2, R3, R4, R5, R9: clean pass
    start_req = 1;
    wait_st(1);
    chk("R2", "gpu held low", gpu_rst_n_o, 0);
    wait_st(2);
    chk("R2", "gpu released, cpu held", {gpu_rst_n_o, cpu_rst_n_o}, 2);
    repeat (4) step();
    gpu_done_i = 1;
    wait_st(3);
    repeat (5) step();
    link_l0_i = 1;
    step(); step();
    chk("R5", "cpu released after L0", cpu_rst_n_o, 1);
    repeat (4) step();
    hs_req = 1;
    step(); step();
    chk("R9", "running", running_o, 1);
    repeat (20) step();
    chk("R9", "still running", running_o & gpu_rst_n_o & cpu_rst_n_o, 1);

    // R10 start ignored while waiting; then R3/R6/R8 GPU timeout and retry
    gpu_done_i = 0; link_l0_i = 0;
    start_req = 1;
    wait_st(2);
    start_req = 1;
    repeat (3) step();
    chk("R10", "gpu_rst_n kept after ignored start", gpu_rst_n_o, 1);
    wait_st(1);
    chk("R6", "log strobe on gpu timeout", log_vld_o, 1);
    chk("R6", "log code gpu", log_code_o, 1);
    chk("R8", "resets reasserted on retry", gpu_rst_n_o, 0);
    chk("R8", "no terminal after first timeout", fatal_code_o, 0);

    // R4, R5, R7: link timeout then handshake timeout -> terminal code 3
    wait_st(2);
    gpu_done_i = 1;
    wait_st(3);
    wait_st(1);
    chk("R4", "log code link", log_code_o, 2);
    link_l0_i = 1;
    wait_st(4);
    wait_st(6);
    chk("R7", "terminal code handshake", fatal_code_o, 3);
    chk("R7", "resets low in terminal", {gpu_rst_n_o, cpu_rst_n_o}, 0);
    repeat (30) step();
    chk("R7", "terminal code kept", fatal_code_o, 3);

    // R2: restart from terminal clears count
    gpu_done_i = 0; link_l0_i = 0;
    start_req = 1;
    step(); step();
    chk("R2", "terminal code cleared", fatal_code_o, 0);
    wait_st(2);
    wait_st(1);
    chk("R2", "count cleared: timeout is a retry", fatal_code_o, 0);

    // R11 confirmation and final tick together
    auto_tick = 0;
    for (int i = 0; i < 200 && m_st != 2; i++) begin force_tick = 1; step(); step(); end
    for (int i = 0; i < 200 && m_st == 2 && m_tc != GT - 1; i++) begin
      force_tick = 1; step(); step();
    end
    chk("R11", "model at last tick", m_tc, GT - 1);
    force_tick = 1;
    step();
    gpu_done_i = 1;
    step();
    chk("R11", "no log when confirmation wins", log_vld_o, 0);
    chk("R11", "gpu stays released", gpu_rst_n_o, 1);
    repeat (5) step();

    finish_run();
  end

endmodule